// File: doc/BRIEF.md
# Byte-Lane Save RAM Adapter

This block sits between a 16-bit big-endian processor data bus and a byte-wide battery-backed save memory held inside the block. A two-bit lane mode places the memory behind both byte lanes, behind the even (high, address bit 0 clear) lane only, or behind the odd (low) lane only. Word and byte accesses from the bus are translated into one or two memory byte accesses. Byte lanes with no memory behind them read back as all ones.

The bus address is first reduced by a save mask. In a single-lane mode the masked address is halved, so a memory of the same depth covers twice the bus range. All writes are qualified by a two-bit gate field taken from an external control register. Reads are issued in the request cycle and their data appears on the next clock cycle. Window decoding and keeping the memory contents across power loss belong to other blocks.

Top module: `sram_lane_adapter`

## Requirements
- R1: Lane mode encoding is 2'b00 both lanes, 2'b01 even lane only, 2'b10 odd lane only. The value 2'b11 is reserved. In that mode no write reaches memory, a word read returns 16'hFFFF and a byte read returns 16'h00FF.
- R2: Every access uses a = addr & save_mask. The mask is applied before any halving and before any lane selection.
- R3: In both-lanes mode, a word write stores wdata[15:8] at a and wdata[7:0] at a+1, with the index wrapping modulo the memory depth. A word read returns {mem[a], mem[a+1]}.
- R4: In both-lanes mode, a byte write stores wdata[7:0] at a, and a byte read returns {8'h00, mem[a]}.
- R5: In even-lane mode, a word write stores wdata[15:8] at a>>1, and a word read returns {mem[a>>1], 8'hFF}.
- R6: In odd-lane mode, a word write stores wdata[7:0] at a>>1, and a word read returns {8'hFF, mem[a>>1]}.
- R7: In a single-lane mode, a byte read at an address whose bit 0 matches the lane returns {8'h00, mem[a>>1]}. The lane's bit 0 is 0 for even and 1 for odd. At the other parity it returns 16'h00FF.
- R8: In a single-lane mode, a byte write stores wdata[7:0] at a>>1 only when address bit 0 matches the lane. Otherwise memory is unchanged.
- R9: A write changes memory only when wr_gate equals 2'b01. Any other value leaves memory unchanged.
- R10: Reads return memory contents whatever the value of wr_gate.
- R11: rvalid is low after reset. It is high in exactly the cycle after an accepted read request (req_valid high, req_write low), and rdata is valid in that cycle. A write is visible to a read issued in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_mode | input | 2 | Lane placement of the memory (R1 encoding) |
| save_mask | input | ADDR_W | Mask ANDed onto the bus address |
| wr_gate | input | 2 | Write gate field from the control register; 2'b01 enables writes |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| addr | input | ADDR_W | Bus byte address |
| wdata | input | 16 | Write data; byte writes use bits [7:0] |
| rdata | output | 16 | Read data, valid when rvalid is high |
| rvalid | output | 1 | Read data valid, one cycle after a read request |

## Verification
The bench first writes a pattern in one mode and then reads it back in another. This exposes a design that confuses the lane order or halves the address in the wrong mode: the even and odd views would not line up with the both-lanes view of the same bytes. Byte writes at the wrong parity are followed by reads of the byte they could have hit. A design that drops the parity check would show the overwritten value. The same method covers a closed write gate and the reserved mode. A word write at the top address checks that the second byte wraps to index zero and does not go out of range. Masked addresses are checked with high address bits set, so a design that skips the mask reads the wrong byte.

// File: rtl/sram_lane_pkg.sv
// Package: shared types for the byte-lane save RAM adapter.
// Assumes a 16-bit big-endian bus: the even byte address carries bits [15:8].
package sram_lane_pkg;
    typedef enum logic [1:0] {
        LANE_BOTH = 2'b00,
        LANE_EVEN = 2'b01,
        LANE_ODD  = 2'b10,
        LANE_NONE = 2'b11
    } lane_mode_e;

    localparam int BUS_W  = 16;
    localparam int BYTE_W = 8;
    localparam logic [1:0] GATE_OPEN = 2'b01;
endpackage

// File: rtl/lane_index.sv
// Module: lane_index
// Turns a masked bus address into the memory indices of the first and second
// byte. Single-lane modes halve the address; the second index is first + 1,
// wrapping at the memory depth. Assumes the memory depth is 2**ADDR_W.
module lane_index
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  lane_mode_e        mode,
    input  logic [ADDR_W-1:0] addr_m,
    output logic [ADDR_W-1:0] idx_a,
    output logic [ADDR_W-1:0] idx_b
);
    // Choose a full or a halved index depending on lane placement.
    always_comb begin
        if (mode == LANE_BOTH) idx_a = addr_m;
        else                   idx_a = {1'b0, addr_m[ADDR_W-1:1]};
        idx_b = idx_a + 1'b1;
    end
endmodule

// File: rtl/byte_ram.sv
// Module: byte_ram
// Byte-wide storage with two synchronous write ports and two combinational
// read ports. Assumes the two write ports never target the same index in
// one cycle (the adapter only uses port B for the byte after port A).
module byte_ram
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we_a,
    input  logic [ADDR_W-1:0] widx_a,
    input  logic [BYTE_W-1:0] din_a,
    input  logic              we_b,
    input  logic [ADDR_W-1:0] widx_b,
    input  logic [BYTE_W-1:0] din_b,
    input  logic [ADDR_W-1:0] ridx_a,
    input  logic [ADDR_W-1:0] ridx_b,
    output logic [BYTE_W-1:0] dout_a,
    output logic [BYTE_W-1:0] dout_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem [DEPTH];

    // Store bytes from both write ports.
    always_ff @(posedge clk) begin
        if (we_a) mem[widx_a] <= din_a;
        if (we_b) mem[widx_b] <= din_b;
    end

    // Read both ports directly from the array.
    always_comb begin
        dout_a = mem[ridx_a];
        dout_b = mem[ridx_b];
    end
endmodule

// File: rtl/read_merge.sv
// Module: read_merge
// Assembles the 16-bit read word from up to two memory bytes. Lanes with no
// memory behind them read as all ones; byte reads return the byte in [7:0]
// with [15:8] zero. Assumes byte_a is the byte at the first index.
module read_merge
    import sram_lane_pkg::*;
(
    input  lane_mode_e        mode,
    input  logic              is_word,
    input  logic              a0,
    input  logic [BYTE_W-1:0] byte_a,
    input  logic [BYTE_W-1:0] byte_b,
    output logic [BUS_W-1:0]  rdata
);
    // Steer bytes onto the lanes for the given mode and access size.
    always_comb begin
        unique case (mode)
            LANE_BOTH: rdata = is_word ? {byte_a, byte_b} : {8'h00, byte_a};
            LANE_EVEN: rdata = is_word ? {byte_a, 8'hFF}
                                       : {8'h00, (a0 ? 8'hFF : byte_a)};
            LANE_ODD:  rdata = is_word ? {8'hFF, byte_a}
                                       : {8'h00, (a0 ? byte_a : 8'hFF)};
            default:   rdata = is_word ? 16'hFFFF : 16'h00FF;
        endcase
    end
endmodule

// File: rtl/sram_lane_adapter.sv
// Module: sram_lane_adapter (top)
// Maps word/byte bus accesses onto a byte-wide save memory placed on the
// even lane, the odd lane or both. Writes are gated by wr_gate == 2'b01.
// Read data is returned one cycle after the request. Assumes requests arrive
// at most one per cycle and that addr is already decoded into the window.
module sram_lane_adapter
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        lane_mode,
    input  logic [ADDR_W-1:0] save_mask,
    input  logic [1:0]        wr_gate,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output logic [BUS_W-1:0]  rdata,
    output logic              rvalid
);
    lane_mode_e        mode_now;
    logic [ADDR_W-1:0] addr_m;
    logic [ADDR_W-1:0] widx_a, widx_b;
    logic              wr_ok;
    logic              we_a, we_b;
    logic [BYTE_W-1:0] din_a, din_b;

    lane_mode_e        rd_mode;
    logic              rd_word;
    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] ridx_a, ridx_b;
    logic [BYTE_W-1:0] byte_a, byte_b;

    // Mask the incoming address and decode the mode.
    always_comb begin
        mode_now = lane_mode_e'(lane_mode);
        addr_m   = addr & save_mask;
        wr_ok    = req_valid && req_write && (wr_gate == GATE_OPEN);
    end

    lane_index #(.ADDR_W(ADDR_W)) u_widx (
        .mode(mode_now), .addr_m(addr_m), .idx_a(widx_a), .idx_b(widx_b)
    );

    // Decide which write ports fire and with which byte.
    always_comb begin
        we_a  = 1'b0;
        we_b  = 1'b0;
        din_a = wdata[7:0];
        din_b = wdata[7:0];
        unique case (mode_now)
            LANE_BOTH: begin
                we_a  = wr_ok;
                we_b  = wr_ok && req_word;
                din_a = req_word ? wdata[15:8] : wdata[7:0];
            end
            LANE_EVEN: begin
                we_a  = wr_ok && (req_word || !addr_m[0]);
                din_a = req_word ? wdata[15:8] : wdata[7:0];
            end
            LANE_ODD: begin
                we_a  = wr_ok && (req_word || addr_m[0]);
            end
            default: ;
        endcase
    end

    // Capture read request fields for the next-cycle data return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid  <= 1'b0;
            rd_mode <= LANE_BOTH;
            rd_word <= 1'b0;
            rd_addr <= '0;
        end else begin
            rvalid <= req_valid && !req_write;
            if (req_valid && !req_write) begin
                rd_mode <= mode_now;
                rd_word <= req_word;
                rd_addr <= addr_m;
            end
        end
    end

    lane_index #(.ADDR_W(ADDR_W)) u_ridx (
        .mode(rd_mode), .addr_m(rd_addr), .idx_a(ridx_a), .idx_b(ridx_b)
    );

    byte_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk(clk),
        .we_a(we_a), .widx_a(widx_a), .din_a(din_a),
        .we_b(we_b), .widx_b(widx_b), .din_b(din_b),
        .ridx_a(ridx_a), .ridx_b(ridx_b),
        .dout_a(byte_a), .dout_b(byte_b)
    );

    read_merge u_merge (
        .mode(rd_mode), .is_word(rd_word), .a0(rd_addr[0]),
        .byte_a(byte_a), .byte_b(byte_b), .rdata(rdata)
    );

    // A closed gate must keep both write ports idle.
    assert_gate_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_gate != GATE_OPEN) |-> !(we_a || we_b));

    // Reserved mode and single-lane modes never use the second write port.
    assert_no_second_port_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_mode != 2'b00) |-> !we_b);

    // A read request produces rvalid on the next cycle, a write does not.
    assert_read_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rvalid);
    assert_no_spurious_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rvalid);

    // Byte reads never drive the upper lane.
    assert_byte_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_word) |=> (rdata[15:8] == 8'h00));

    // Even-lane word reads fill the low lane with ones.
    assert_even_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_word && lane_mode == 2'b01)
        |=> (rdata[7:0] == 8'hFF));

    // Odd-lane word reads fill the high lane with ones.
    assert_odd_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_word && lane_mode == 2'b10)
        |=> (rdata[15:8] == 8'hFF));
endmodule

// File: tb/sim_sram_lane_adapter.sv
module sim_sram_lane_adapter;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int NVEC = 26;

    // Vector: {req[3:0], wr, word, mode[1:0], addr[7:0], data[15:0], exp[15:0]}
    localparam logic [47:0] VEC [NVEC] = '{
        {4'd3, 1'b1, 1'b1, 2'b00, 8'h10, 16'hA1B2, 16'h0000}, // R3 word write
        {4'd3, 1'b0, 1'b1, 2'b00, 8'h10, 16'h0000, 16'hA1B2}, // R3 word read
        {4'd4, 1'b0, 1'b0, 2'b00, 8'h11, 16'h0000, 16'h00B2}, // R4 byte read
        {4'd4, 1'b1, 1'b0, 2'b00, 8'h11, 16'h0077, 16'h0000}, // R4 byte write
        {4'd4, 1'b0, 1'b1, 2'b00, 8'h10, 16'h0000, 16'hA177}, // R4 seen as word
        {4'd5, 1'b1, 1'b1, 2'b01, 8'h40, 16'hC3D4, 16'h0000}, // R5 mem[20]=C3
        {4'd5, 1'b0, 1'b1, 2'b01, 8'h40, 16'h0000, 16'hC3FF}, // R5
        {4'd7, 1'b0, 1'b0, 2'b01, 8'h40, 16'h0000, 16'h00C3}, // R7 even match
        {4'd7, 1'b0, 1'b0, 2'b01, 8'h41, 16'h0000, 16'h00FF}, // R7 even other
        {4'd6, 1'b1, 1'b1, 2'b10, 8'h42, 16'h5566, 16'h0000}, // R6 mem[21]=66
        {4'd6, 1'b0, 1'b1, 2'b10, 8'h42, 16'h0000, 16'hFF66}, // R6
        {4'd7, 1'b0, 1'b0, 2'b10, 8'h43, 16'h0000, 16'h0066}, // R7 odd match
        {4'd7, 1'b0, 1'b0, 2'b10, 8'h42, 16'h0000, 16'h00FF}, // R7 odd other
        {4'd8, 1'b1, 1'b0, 2'b01, 8'h43, 16'h0099, 16'h0000}, // R8 ignored
        {4'd8, 1'b0, 1'b1, 2'b10, 8'h42, 16'h0000, 16'hFF66}, // R8 unchanged
        {4'd8, 1'b1, 1'b0, 2'b10, 8'h42, 16'h0011, 16'h0000}, // R8 ignored
        {4'd8, 1'b0, 1'b0, 2'b10, 8'h43, 16'h0000, 16'h0066}, // R8 unchanged
        {4'd8, 1'b1, 1'b0, 2'b10, 8'h43, 16'h0044, 16'h0000}, // R8 accepted
        {4'd8, 1'b0, 1'b1, 2'b01, 8'h42, 16'h0000, 16'h44FF}, // R8 via even view
        {4'd3, 1'b0, 1'b1, 2'b00, 8'h20, 16'h0000, 16'hC344}, // R3 lanes line up
        {4'd3, 1'b1, 1'b1, 2'b00, 8'hFF, 16'h1234, 16'h0000}, // R3 wrap write
        {4'd3, 1'b0, 1'b0, 2'b00, 8'h00, 16'h0000, 16'h0034}, // R3 wrapped byte
        {4'd1, 1'b0, 1'b1, 2'b11, 8'h10, 16'h0000, 16'hFFFF}, // R1 reserved word
        {4'd1, 1'b0, 1'b0, 2'b11, 8'h10, 16'h0000, 16'h00FF}, // R1 reserved byte
        {4'd1, 1'b1, 1'b1, 2'b11, 8'h10, 16'h0000, 16'h0000}, // R1 write dropped
        {4'd1, 1'b0, 1'b1, 2'b00, 8'h10, 16'h0000, 16'hA177}  // R1 unchanged
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    lane_mode = 2'b00;
    logic [AW-1:0] save_mask = 8'hFF;
    logic [1:0]    wr_gate = 2'b01;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic          req_word = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic [15:0]   rdata;
    logic          rvalid;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_lane_adapter #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .lane_mode(lane_mode), .save_mask(save_mask),
        .wr_gate(wr_gate), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One access: drive at negedge, clock it, sample at the next negedge.
    task automatic do_op(input bit wr, input bit word, input logic [1:0] md,
                         input logic [7:0] a, input logic [15:0] d,
                         input logic [15:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_word = word;
        lane_mode = md; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (wr) check(rvalid == 1'b0, {tag, " rvalid after write"}, {15'd0, rvalid}, 16'h0);
        else begin
            check(rvalid == 1'b1, {tag, " rvalid after read"}, {15'd0, rvalid}, 16'h1);
            check(rdata == exp, {tag, " rdata"}, rdata, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(rvalid == 1'b0, "R11 reset rvalid", {15'd0, rvalid}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rvalid == 1'b0, "R11 idle rvalid", {15'd0, rvalid}, 16'h0);

        for (int i = 0; i < NVEC; i++) begin
            logic [47:0] v;
            v = VEC[i];
            do_op(v[43], v[42], v[41:40], v[39:32], v[31:16], v[15:0],
                  $sformatf("R%0d row %0d", v[47:44], i));
        end

        // R9: closed gate values leave memory untouched
        wr_gate = 2'b00;
        do_op(1'b1, 1'b1, 2'b00, 8'h10, 16'hBEEF, 16'h0, "R9 gate 00");
        // R10: reads still work with the gate closed
        do_op(1'b0, 1'b1, 2'b00, 8'h10, 16'h0, 16'hA177, "R10 read gate 00");
        wr_gate = 2'b11;
        do_op(1'b1, 1'b0, 2'b00, 8'h10, 16'h00EE, 16'h0, "R9 gate 11");
        wr_gate = 2'b10;
        do_op(1'b1, 1'b1, 2'b01, 8'h40, 16'h0F0F, 16'h0, "R9 gate 10");
        do_op(1'b0, 1'b1, 2'b01, 8'h40, 16'h0, 16'hC3FF, "R10 read gate 10");
        wr_gate = 2'b01;
        do_op(1'b0, 1'b1, 2'b00, 8'h10, 16'h0, 16'hA177, "R9 memory unchanged");

        // R2: mask applied before indexing
        do_op(1'b1, 1'b1, 2'b00, 8'h0A, 16'h5AA5, 16'h0, "R2 setup");
        save_mask = 8'h0F;
        do_op(1'b0, 1'b1, 2'b00, 8'hFA, 16'h0, 16'h5AA5, "R2 masked read");
        do_op(1'b1, 1'b0, 2'b00, 8'hEB, 16'h0033, 16'h0, "R2 masked write");
        save_mask = 8'hFF;
        do_op(1'b0, 1'b1, 2'b00, 8'h0A, 16'h0, 16'h5A33, "R2 masked write landed");

        // R11: write then immediate read sees new data
        do_op(1'b1, 1'b0, 2'b00, 8'h80, 16'h00C7, 16'h0, "R11 write");
        do_op(1'b0, 1'b0, 2'b00, 8'h80, 16'h0, 16'h00C7, "R11 read back");
        @(negedge clk);
        check(rvalid == 1'b0, "R11 rvalid drops", {15'd0, rvalid}, 16'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule